// File: doc/BRIEF.md
# Still-Capture Exposure Sequencer

This block runs one still-image capture for an interline image sensor that has an electronic shutter, a substrate-bias control line and a mechanical shutter. While idle it stays in continuous preview: the shutter is open and the bias line is low, so the substrate bias keeps its anti-blooming setting. When a capture is requested, it raises the bias line and waits a settling time counted in reference-clock cycles. It then issues a burst of substrate discharge pulses, one per horizontal blanking tick, to empty the photodiodes at the start of the exposure.

The exposure lasts a programmed number of line ticks. The mechanical shutter is then closed, and high-speed vertical sweep fields are requested to drain the blooming charge gathered under the closed shutter. After that a two-field frame readout is started: a one-cycle trigger, the first field, then the second field. When the second field ends, the block returns to preview. The reference clock, the lead time, the burst length, the sweep count and the lines per field are all parameters.

Top module: `ccd_capture_seq`

## Requirements
- R1: After reset the block is idle: `bias_hold`=0, `shutter_open`=1, and `sub_pulse`, `sweep_req`, `read_go`, `read_active`, `read_field` and `busy` are all 0.
- R2: A `cap_req` sampled high while idle sets `busy` and `bias_hold` on the next cycle. Both stay high until the sequence ends.
- R3: `bias_hold` is high for at least LEAD_CYC = (CLK_HZ/1000)*LEAD_MS clock cycles before the first discharge pulse. With the default settings this is 20 ms at 22.5 MHz.
- R4: Each capture produces exactly NPULSE discharge pulses (NPULSE at least 20, checked at elaboration). Each pulse is one cycle of `sub_pulse`, appearing the cycle after an `hd_tick` in the burst phase.
- R5: The exposure lasts the number of `hd_tick`s given by `exp_lines`, latched when the request is accepted, with 0 treated as 1. `shutter_open` falls at the edge that samples the last exposure tick.
- R6: `sweep_req` is high from the closing of the shutter until SWEEP_FIELDS `vd_tick`s have been counted (SWEEP_FIELDS at least 2, checked at elaboration). It is never high together with `read_active`.
- R7: The edge that ends the sweep raises `read_active` and gives a one-cycle `read_go`. `read_field` is 0 for FIELD_LINES `hd_tick`s, then 1 for FIELD_LINES `hd_tick`s, and then readout ends.
- R8: No discharge pulse appears while the shutter is closed, during the sweep or during readout.
- R9: A `cap_req` while `busy` is ignored, and `exp_lines` changes during a sequence have no effect on it.
- R10: When the second readout field ends, the block is idle again (`busy`=0, `bias_hold`=0, `shutter_open`=1). A request held high at that moment starts a new sequence one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hd_tick | input | 1 | One-cycle horizontal blanking tick |
| vd_tick | input | 1 | One-cycle field tick |
| cap_req | input | 1 | Still-capture request |
| exp_lines | input | EXP_W | Exposure length in line ticks |
| sub_pulse | output | 1 | Substrate discharge pulse |
| bias_hold | output | 1 | Substrate-bias control level, high during a capture |
| shutter_open | output | 1 | Mechanical shutter command, 1 = open |
| sweep_req | output | 1 | Request for high-speed vertical sweep fields |
| read_go | output | 1 | One-cycle frame readout trigger |
| read_active | output | 1 | High for the whole two-field readout |
| read_field | output | 1 | Readout field index, 0 = first, 1 = second |
| busy | output | 1 | A capture sequence is running |

## Verification
`busy` and `bias_hold` rise one cycle after the accepted request. Each `sub_pulse` and `read_go` is due one cycle after the tick that causes it. The level outputs (`shutter_open`, `sweep_req`, `read_active`, `read_field`) and the return to idle change at the very edge that samples the final counted tick. The bench's reference model advances at the same rising edge from the inputs driven half a cycle earlier. Every output is compared at the following falling edge, so each check sees the cycle in which its result becomes due. Separate counters check the lead-time gap, the number of pulses in each burst and the absence of pulses outside the burst.

// File: rtl/ccdseq_pkg.sv
package ccdseq_pkg;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_LEAD   = 3'd1,
      PH_BURST  = 3'd2,
      PH_EXPOSE = 3'd3,
      PH_SWEEP  = 3'd4,
      PH_READ   = 3'd5
   } phase_t;

   // tick-counted channels, one per timed phase after the lead
   localparam int NCH       = 4;
   localparam int CH_BURST  = 0;
   localparam int CH_EXPOSE = 1;
   localparam int CH_SWEEP  = 2;
   localparam int CH_LINE   = 3;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic phase_t owner_of(input int ch);
      case (ch)
         CH_BURST:  return PH_BURST;
         CH_EXPOSE: return PH_EXPOSE;
         CH_SWEEP:  return PH_SWEEP;
         default:   return PH_READ;
      endcase
   endfunction

endpackage

// File: rtl/ccdseq_tick_counter.sv
module ccdseq_tick_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic [W-1:0] limit,
   output logic         hit
);

   logic [W-1:0] cnt;

   // hit marks the event that completes the programmed count
   assign hit = en && (cnt == (limit - W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (en) begin
         cnt <= hit ? '0 : cnt + W'(1);
      end
   end

endmodule

// File: rtl/ccdseq_lead_timer.sv
module ccdseq_lead_timer #(
   parameter int LEAD_CYC = 450000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);

   generate
      if (LEAD_CYC <= 1) begin : g_single
         assign done = run;
      end else begin : g_count
         localparam int LW = $clog2(LEAD_CYC + 1);
         logic [LW-1:0] cnt;

         assign done = run && (cnt == LW'(LEAD_CYC - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run) begin
               cnt <= '0;
            end else if (!done) begin
               cnt <= cnt + LW'(1);
            end
         end
      end
   endgenerate

endmodule

// File: rtl/ccdseq_phase_fsm.sv
module ccdseq_phase_fsm
   import ccdseq_pkg::*;
#(
   parameter int EXP_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_req,
   input  logic [EXP_W-1:0] exp_lines,
   input  logic             lead_done,
   input  logic [NCH-1:0]   ch_hit,
   output phase_t           phase,
   output logic [EXP_W-1:0] exp_q,
   output logic             field
);

   phase_t phase_nx;

   always_comb begin
      phase_nx = phase;
      case (phase)
         PH_IDLE:   if (cap_req)           phase_nx = PH_LEAD;
         PH_LEAD:   if (lead_done)         phase_nx = PH_BURST;
         PH_BURST:  if (ch_hit[CH_BURST])  phase_nx = PH_EXPOSE;
         PH_EXPOSE: if (ch_hit[CH_EXPOSE]) phase_nx = PH_SWEEP;
         PH_SWEEP:  if (ch_hit[CH_SWEEP])  phase_nx = PH_READ;
         PH_READ:   if (ch_hit[CH_LINE] && field) phase_nx = PH_IDLE;
         default:                          phase_nx = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         exp_q <= EXP_W'(1);
         field <= 1'b0;
      end else begin
         phase <= phase_nx;
         // exposure length is frozen at acceptance; zero becomes one line
         if (phase == PH_IDLE && cap_req) begin
            exp_q <= (exp_lines == '0) ? EXP_W'(1) : exp_lines;
         end
         if (phase == PH_SWEEP && ch_hit[CH_SWEEP]) begin
            field <= 1'b0;
         end else if (phase == PH_READ && ch_hit[CH_LINE]) begin
            field <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ccdseq_out_stage.sv
module ccdseq_out_stage
   import ccdseq_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  phase_t phase,
   input  logic   hd_tick,
   input  logic   sweep_done,
   input  logic   field,
   output logic   sub_pulse,
   output logic   bias_hold,
   output logic   shutter_open,
   output logic   sweep_req,
   output logic   read_go,
   output logic   read_active,
   output logic   read_field,
   output logic   busy
);

   logic sub_q;
   logic go_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= 1'b0;
         go_q  <= 1'b0;
      end else begin
         sub_q <= (phase == PH_BURST) && hd_tick;
         go_q  <= (phase == PH_SWEEP) && sweep_done;
      end
   end

   always_comb begin
      busy         = (phase != PH_IDLE);
      bias_hold    = busy;
      shutter_open = (phase == PH_IDLE) || (phase == PH_LEAD) ||
                     (phase == PH_BURST) || (phase == PH_EXPOSE);
      sweep_req    = (phase == PH_SWEEP);
      read_active  = (phase == PH_READ);
      read_field   = read_active && field;
      sub_pulse    = sub_q;
      read_go      = go_q;
   end

endmodule

// File: rtl/ccd_capture_seq.sv
module ccd_capture_seq
   import ccdseq_pkg::*;
#(
   parameter int CLK_HZ       = 22500000,
   parameter int LEAD_MS      = 20,
   parameter int NPULSE       = 20,
   parameter int SWEEP_FIELDS = 2,
   parameter int FIELD_LINES  = 775,
   parameter int EXP_W        = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hd_tick,
   input  logic             vd_tick,
   input  logic             cap_req,
   input  logic [EXP_W-1:0] exp_lines,
   output logic             sub_pulse,
   output logic             bias_hold,
   output logic             shutter_open,
   output logic             sweep_req,
   output logic             read_go,
   output logic             read_active,
   output logic             read_field,
   output logic             busy
);

   localparam int LEAD_CYC = (CLK_HZ / 1000) * LEAD_MS;
   localparam int CMAX     = max_of(max_of(NPULSE, SWEEP_FIELDS),
                                    max_of(FIELD_LINES, (1 << EXP_W) - 1));
   localparam int CW       = $clog2(CMAX + 1);

   generate
      if (NPULSE < 20) begin : g_bad_npulse
         $error("NPULSE must be 20 or more");
      end
      if (SWEEP_FIELDS < 2) begin : g_bad_sweep
         $error("SWEEP_FIELDS must be 2 or more");
      end
      if (FIELD_LINES < 1) begin : g_bad_lines
         $error("FIELD_LINES must be 1 or more");
      end
      if (LEAD_CYC < 1) begin : g_bad_lead
         $error("lead time must be at least one clock");
      end
      if (EXP_W < 1 || EXP_W > 16) begin : g_bad_expw
         $error("EXP_W must lie in 1..16");
      end
   endgenerate

   phase_t           phase;
   logic [EXP_W-1:0] exp_q;
   logic             field;
   logic             lead_done;
   logic [NCH-1:0]   ch_en;
   logic [NCH-1:0]   ch_clr;
   logic [NCH-1:0]   ch_hit;
   logic [CW-1:0]    ch_limit [NCH];

   ccdseq_lead_timer #(.LEAD_CYC(LEAD_CYC)) u_lead (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (phase == PH_LEAD),
      .done (lead_done)
   );

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         if (i == CH_SWEEP) begin : g_vd
            assign ch_en[i] = vd_tick && (phase == owner_of(i));
         end else begin : g_hd
            assign ch_en[i] = hd_tick && (phase == owner_of(i));
         end

         if (i == CH_BURST) begin : g_lim_burst
            assign ch_limit[i] = CW'(NPULSE);
         end else if (i == CH_EXPOSE) begin : g_lim_exp
            assign ch_limit[i] = CW'(exp_q);
         end else if (i == CH_SWEEP) begin : g_lim_sweep
            assign ch_limit[i] = CW'(SWEEP_FIELDS);
         end else begin : g_lim_line
            assign ch_limit[i] = CW'(FIELD_LINES);
         end

         assign ch_clr[i] = (phase != owner_of(i));

         ccdseq_tick_counter #(.W(CW)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .clr  (ch_clr[i]),
            .en   (ch_en[i]),
            .limit(ch_limit[i]),
            .hit  (ch_hit[i])
         );
      end
   endgenerate

   ccdseq_phase_fsm #(.EXP_W(EXP_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap_req  (cap_req),
      .exp_lines(exp_lines),
      .lead_done(lead_done),
      .ch_hit   (ch_hit),
      .phase    (phase),
      .exp_q    (exp_q),
      .field    (field)
   );

   ccdseq_out_stage u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .phase       (phase),
      .hd_tick     (hd_tick),
      .sweep_done  (ch_hit[CH_SWEEP]),
      .field       (field),
      .sub_pulse   (sub_pulse),
      .bias_hold   (bias_hold),
      .shutter_open(shutter_open),
      .sweep_req   (sweep_req),
      .read_go     (read_go),
      .read_active (read_active),
      .read_field  (read_field),
      .busy        (busy)
   );

endmodule

// File: rtl/ccd_capture_seq_chk.sv
module ccd_capture_seq_chk #(
   parameter int CLK_HZ  = 22500000,
   parameter int LEAD_MS = 20
) (
   input logic clk,
   input logic rst_n,
   input logic cap_req,
   input logic sub_pulse,
   input logic bias_hold,
   input logic shutter_open,
   input logic sweep_req,
   input logic read_go,
   input logic read_active,
   input logic read_field,
   input logic busy
);

   localparam int LEAD_CYC = (CLK_HZ / 1000) * LEAD_MS;

   // cycles the bias line has been high, saturating just past the lead
   int lead_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lead_seen <= 0;
      end else if (!bias_hold) begin
         lead_seen <= 0;
      end else if (lead_seen <= LEAD_CYC) begin
         lead_seen <= lead_seen + 1;
      end
   end

   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cap_req) |=> (busy && bias_hold));

   assert_lead_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sub_pulse |-> (lead_seen >= LEAD_CYC));

   assert_pulse_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sub_pulse |-> (shutter_open && !sweep_req && !read_active));

   assert_sweep_closed_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_req |-> (!shutter_open && bias_hold));

   assert_sweep_read_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sweep_req, read_active}));

   assert_go_first_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      read_go |-> (read_active && !read_field));

   assert_ignore_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !read_active && cap_req) |=> busy);

   assert_idle_levels_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!bias_hold && shutter_open && !sweep_req && !read_active));

endmodule

bind ccd_capture_seq ccd_capture_seq_chk #(
   .CLK_HZ (CLK_HZ),
   .LEAD_MS(LEAD_MS)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cap_req     (cap_req),
   .sub_pulse   (sub_pulse),
   .bias_hold   (bias_hold),
   .shutter_open(shutter_open),
   .sweep_req   (sweep_req),
   .read_go     (read_go),
   .read_active (read_active),
   .read_field  (read_field),
   .busy        (busy)
);

// File: tb/ccd_capture_seq_test.sv
`timescale 1ns/1ps
module ccd_capture_seq_test;

   localparam int CLK_HZ  = 1000;
   localparam int LEAD_MS = 20;
   localparam int LEAD    = (CLK_HZ / 1000) * LEAD_MS;
   localparam int NPULSE  = 20;
   localparam int SWEEPS  = 2;
   localparam int FLINES  = 6;
   localparam int EXP_W   = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             hd_tick = 1'b0;
   logic             vd_tick = 1'b0;
   logic             cap_req = 1'b0;
   logic [EXP_W-1:0] exp_lines = '0;
   logic sub_pulse, bias_hold, shutter_open, sweep_req;
   logic read_go, read_active, read_field, busy;

   always #10 clk = ~clk;

   ccd_capture_seq #(
      .CLK_HZ(CLK_HZ), .LEAD_MS(LEAD_MS), .NPULSE(NPULSE),
      .SWEEP_FIELDS(SWEEPS), .FIELD_LINES(FLINES), .EXP_W(EXP_W)
   ) uut (
      .clk(clk), .rst_n(rst_n), .hd_tick(hd_tick), .vd_tick(vd_tick),
      .cap_req(cap_req), .exp_lines(exp_lines), .sub_pulse(sub_pulse),
      .bias_hold(bias_hold), .shutter_open(shutter_open), .sweep_req(sweep_req),
      .read_go(read_go), .read_active(read_active), .read_field(read_field),
      .busy(busy)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 1'b0;

   // ---------------- reference model ----------------
   int m_ph = 0;   // 0 idle 1 lead 2 burst 3 expose 4 sweep 5 read
   int m_cnt = 0;
   int m_exp = 1;
   int m_field = 0;
   bit m_sub = 1'b0;
   bit m_go = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_cnt = 0; m_exp = 1; m_field = 0; m_sub = 0; m_go = 0;
      end else begin
         m_sub = (m_ph == 2) && hd_tick;
         m_go  = 1'b0;
         case (m_ph)
            0: if (cap_req) begin
                  m_ph = 1; m_cnt = 0;
                  m_exp = (exp_lines == 0) ? 1 : int'(exp_lines);
               end
            1: begin
                  m_cnt++;
                  if (m_cnt == LEAD) begin m_ph = 2; m_cnt = 0; end
               end
            2: if (hd_tick) begin
                  m_cnt++;
                  if (m_cnt == NPULSE) begin m_ph = 3; m_cnt = 0; end
               end
            3: if (hd_tick) begin
                  m_cnt++;
                  if (m_cnt == m_exp) begin m_ph = 4; m_cnt = 0; end
               end
            4: if (vd_tick) begin
                  m_cnt++;
                  if (m_cnt == SWEEPS) begin
                     m_ph = 5; m_cnt = 0; m_field = 0; m_go = 1'b1;
                  end
               end
            default: if (hd_tick) begin
                  m_cnt++;
                  if (m_cnt == FLINES) begin
                     m_cnt = 0;
                     if (m_field == 0) m_field = 1;
                     else m_ph = 0;
                  end
               end
         endcase
      end
   end

   // ---------------- checking ----------------
   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   int cyc = 0;
   int hd_per = 4;
   int vd_per = 30;
   int rise_cyc = 0;
   bit want_first = 1'b0;
   int pulses = 0;
   int stray = 0;
   bit prev_bias = 1'b0;
   bit prev_busy = 1'b0;

   task automatic compare_all();
      check("R2", "bias_hold", bias_hold, m_ph != 0);
      check("R9", "busy", busy, m_ph != 0);
      check("R5", "shutter_open", shutter_open, m_ph <= 3);
      check("R4", "sub_pulse", sub_pulse, m_sub);
      check("R6", "sweep_req", sweep_req, m_ph == 4);
      check("R7", "read_active", read_active, m_ph == 5);
      check("R7", "read_field", read_field, (m_ph == 5) && (m_field == 1));
      check("R7", "read_go", read_go, m_go);
      // lead gap and burst bookkeeping
      if (bias_hold && !prev_bias) begin rise_cyc = cyc; want_first = 1'b1; end
      if (sub_pulse) begin
         pulses++;
         if (!shutter_open || sweep_req || read_active) stray++;
         if (want_first) begin
            check("R3", "lead gap", (cyc - rise_cyc) >= LEAD + 1, 1);
            want_first = 1'b0;
         end
      end
      if (!busy && prev_busy) begin
         check("R4", "pulses per capture", pulses, NPULSE);
         check("R10", "idle bias after readout", bias_hold, 0);
         pulses = 0;
      end
      prev_bias = bias_hold;
      prev_busy = busy;
   endtask

   task automatic step(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         if (rst_n) compare_all();
         cyc++;
         hd_tick = (cyc % hd_per) == 0;
         vd_tick = (cyc % vd_per) == 0;
      end
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 5000; k++) begin
         step(1);
         if (!busy) break;
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "bias_hold", bias_hold, 0);
      check("R1", "shutter_open", shutter_open, 1);
      check("R1", "busy", busy, 0);
      check("R1", "sub_pulse", sub_pulse, 0);
      check("R1", "sweep/read", {sweep_req, read_go, read_active, read_field}, 0);
      rst_n = 1'b1;
      step(5);

      // capture 1: ten-line exposure, ticks every 4 cycles
      hd_per = 4; vd_per = 30; exp_lines = 8'd10;
      cap_req = 1'b1; step(1); cap_req = 1'b0;
      wait_idle();
      step(10);

      // capture 2: zero exposure (one line), extra requests and a length change mid-run (R9)
      hd_per = 3; vd_per = 25; exp_lines = 8'd0;
      cap_req = 1'b1; step(1); cap_req = 1'b0;
      step(10);
      exp_lines = 8'd200;
      cap_req = 1'b1; step(2); cap_req = 1'b0;
      step(60);
      cap_req = 1'b1; step(1); cap_req = 1'b0;
      wait_idle();
      step(10);

      // capture 3: longest exposure, request held so a second run follows (R10)
      hd_per = 2; vd_per = 17; exp_lines = 8'd255;
      cap_req = 1'b1;
      wait_idle();
      step(3);
      check("R10", "back-to-back restart", busy, 1);
      cap_req = 1'b0;
      exp_lines = 8'd3;
      wait_idle();
      step(20);

      check("R8", "pulses outside burst", stray, 0);
      finish_run();
   end

endmodule